// File: doc/BRIEF.md
# Redundant Log Filter Table

This block sits next to a core's undo-logging path and decides, for every log request, whether the log is still needed. A request carries a memory address. The block keeps a small set-associative table of memory blocks that have already been logged. Each remembered block is stamped with the ID of the durable transaction that logged it. A second log of the same 64-byte block inside the same transaction is reported as redundant, so the logging path can drop it. Any other request is reported as "proceed", and the block is recorded as logged by the current transaction.

The transaction ID lives in a counter inside the block. A pulse on the transaction-begin input advances it, so every entry left by an earlier transaction goes stale at once and no flush is needed. A stale entry is treated as a miss. It is refreshed in place and is not reported as redundant. When the counter wraps back to zero, the whole table is invalidated in that same cycle. This stops an entry from a much older transaction from matching by coincidence. The table accepts one request per clock and answers each accepted request one cycle later.

Top module: `redundant_log_filter`

## Requirements
- R1: While reset is low and in the first cycle after it, `req_ready` and `resp_valid` are 0. From the second cycle after reset, `req_ready` is 1. All entries start invalid, so the first request for any block after reset gets "proceed".
- R2: Addresses match at block granularity. Bits [5:0] are ignored, bits [8:6] select one of 8 sets, and bits [39:9] form the tag. Two addresses that differ only in bits [5:0] are the same block. Addresses with the same tag but different sets are different blocks.
- R3: A request is accepted in a cycle where `req_valid` and `req_ready` are both 1. In the next cycle `resp_valid` is 1, and exactly one of `resp_redundant` and `resp_proceed` is 1. A block logged earlier in the current transaction gets redundant. A block not present gets proceed.
- R4: A `tx_begin` pulse advances the transaction ID by one. An entry written under an earlier ID counts as a miss: it gets proceed and is re-stamped, so the next request for it in the same transaction gets redundant.
- R5: A request accepted in the same cycle as `tx_begin` is judged and recorded under the new transaction ID.
- R6: Each set holds 8 blocks at once. Requests in one set never displace blocks held in another set.
- R7: A miss in a full set replaces the least recently accessed block of that set. An access is any accepted request that hits or inserts, whether it is redundant or refreshed.
- R8: When the transaction ID wraps from its all-ones value to 0, every entry is invalidated. A request in the wrap cycle is recorded after that clear.
- R9: Requests may come on back-to-back cycles. A request sees every update made by the request accepted one cycle before it.
- R10: A cycle with `req_valid` low gives `resp_valid` 0 in the next cycle and leaves the table unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_begin | input | 1 | One-cycle pulse: a new durable transaction starts |
| req_valid | input | 1 | A log request is offered |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_addr | input | 40 | Byte address of the location to be logged |
| resp_valid | output | 1 | Response for the request accepted one cycle earlier |
| resp_redundant | output | 1 | That log repeats one already made in this transaction and may be dropped |
| resp_proceed | output | 1 | That log must be performed; the block is now recorded |

## Verification
Two events can fall in the same cycle: a transaction begin and a lookup. When the counter wraps, the wrap-triggered invalidation and an insert can also coincide. The bench makes both happen on purpose. It repeats a block that was just logged in the same cycle as `tx_begin`, where the request must get proceed under the new ID. It also places a request in the exact cycle the ID rolls over to zero. Every clock, a behavioural model built from per-entry timestamps predicts the response and compares it with the design's. That model applies the ID advance and any wrap clear before the lookup. A request in the cycle after such a coincidence then checks whether the insert survived the clear.

// File: rtl/rlf_pkg.sv
// Package: shared types of the redundant log filter.
// Assumes nothing beyond IEEE 1800-2017.
package rlf_pkg;

    // Outcome of one lookup against the selected set.
    typedef enum logic [1:0] {
        LK_MISS      = 2'd0,   // no valid way holds the tag
        LK_STALE     = 2'd1,   // tag present, stamped by an older transaction
        LK_REDUNDANT = 2'd2    // tag present, stamped by the current transaction
    } lookup_e;

endpackage

// File: rtl/rlf_txid_reg.sv
// Module: rlf_txid_reg
// Holds the ID of the running transaction and advances it on tx_begin.
// Gives the effective ID for a request in the same cycle (the new one
// when tx_begin is high) and flags the cycle in which the ID wraps to 0.
// Assumes tx_begin is a single-cycle pulse per transaction start.
module rlf_txid_reg #(
    parameter int TXID_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_begin,
    output logic [TXID_W-1:0] eff_txid,
    output logic              wrap_now
);

    logic [TXID_W-1:0] cur_q;

    // Effective ID seen by a request issued in this cycle.
    always_comb begin
        eff_txid = tx_begin ? cur_q + TXID_W'(1) : cur_q;
        wrap_now = tx_begin && (&cur_q);
    end

    // Transaction counter: cleared by reset, advanced by tx_begin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else if (tx_begin) begin
            cur_q <= cur_q + TXID_W'(1);
        end
    end

    // R4
    txid_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_begin |=> (cur_q == $past(eff_txid)));

    // R4
    txid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_begin |=> $stable(cur_q));

endmodule

// File: rtl/rlf_way_match.sv
// Module: rlf_way_match
// Compares a request tag against every way of one set in parallel and
// classifies the result as miss, stale hit or redundant hit.
// Assumes the valid vector is already masked for any same-cycle clear.
module rlf_way_match
    import rlf_pkg::*;
#(
    parameter int WAYS   = 8,
    parameter int TAG_W  = 31,
    parameter int TXID_W = 8,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         active,
    input  logic [WAYS-1:0]              way_valid,
    input  logic [WAYS-1:0][TAG_W-1:0]   way_tag,
    input  logic [WAYS-1:0][TXID_W-1:0]  way_txid,
    input  logic [TAG_W-1:0]             req_tag,
    input  logic [TXID_W-1:0]            eff_txid,
    output logic                         hit,
    output logic [WAY_W-1:0]             hit_way,
    output lookup_e                      outcome
);

    logic [WAYS-1:0] hit_vec;

    // One comparator per way.
    genvar gw;
    generate
        for (gw = 0; gw < WAYS; gw++) begin : g_cmp
            assign hit_vec[gw] = way_valid[gw] && (way_tag[gw] == req_tag);
        end
    endgenerate

    // Encode the hitting way (lowest index) and classify the lookup.
    always_comb begin
        hit     = |hit_vec;
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
        if (!hit)
            outcome = LK_MISS;
        else if (way_txid[hit_way] == eff_txid)
            outcome = LK_REDUNDANT;
        else
            outcome = LK_STALE;
    end

    // R6
    single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> $onehot0(hit_vec));

endmodule

// File: rtl/rlf_lru_set.sv
// Module: rlf_lru_set
// True-LRU state of one set held as a permutation of per-way ages
// (0 = most recent). Picks the victim for a miss: the lowest-index
// invalid way if one exists, else the way of the largest age.
// Assumes at most one touch per cycle.
module rlf_lru_set #(
    parameter int WAYS   = 8,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch,
    input  logic [WAY_W-1:0] touch_way,
    input  logic [WAYS-1:0]  way_valid,
    output logic [WAY_W-1:0] victim
);

    logic [WAY_W-1:0] age_q [WAYS];
    logic [WAYS-1:0]  oldest_vec;

    // Victim selection: free way first, else the oldest way.
    always_comb begin
        victim = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            oldest_vec[w] = (age_q[w] == WAY_W'(WAYS - 1));
            if (oldest_vec[w]) victim = WAY_W'(w);
        end
        if (!(&way_valid)) begin
            for (int w = WAYS - 1; w >= 0; w--) begin
                if (!way_valid[w]) victim = WAY_W'(w);
            end
        end
    end

    // Age update: touched way becomes youngest, younger ways age by one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WAYS; w++) age_q[w] <= WAY_W'(w);
        end else if (touch) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way)
                    age_q[w] <= '0;
                else if (age_q[w] < age_q[touch_way])
                    age_q[w] <= age_q[w] + WAY_W'(1);
            end
        end
    end

    // R7
    lru_one_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(oldest_vec) == 1);

    // R7
    lru_touch_young_chk: assert property (@(posedge clk) disable iff (!rst_n)
        touch |=> (age_q[$past(touch_way)] == '0));

endmodule

// File: rtl/redundant_log_filter.sv
// Module: redundant_log_filter (top)
// Set-associative table that marks repeated undo-log requests for the
// same 64-byte block within one transaction as redundant. Lookup and
// update take one cycle; the response is registered and appears in the
// cycle after acceptance. Assumes tx_begin is a single-cycle pulse.
module redundant_log_filter
    import rlf_pkg::*;
#(
    parameter int ADDR_W = 40,
    parameter int OFF_W  = 6,
    parameter int SETS   = 8,
    parameter int WAYS   = 8,
    parameter int TXID_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_begin,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              resp_valid,
    output logic              resp_redundant,
    output logic              resp_proceed
);

    localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int TAG_W = ADDR_W - OFF_W - SET_W;

    // Table storage.
    logic [SETS-1:0][WAYS-1:0] valid_q;
    logic [TAG_W-1:0]          tag_q  [SETS][WAYS];
    logic [TXID_W-1:0]         txid_q [SETS][WAYS];

    logic                            ready_q;
    logic                            accept;
    logic [SET_W-1:0]                sel_set;
    logic [TAG_W-1:0]                req_tag;
    logic                            unused_offset;
    logic [TXID_W-1:0]               eff_txid;
    logic                            wrap_now;
    logic [WAYS-1:0]                 rd_valid;
    logic [WAYS-1:0][TAG_W-1:0]      rd_tag;
    logic [WAYS-1:0][TXID_W-1:0]     rd_txid;
    logic                            hit;
    logic [WAY_W-1:0]                hit_way;
    lookup_e                         outcome;
    logic [WAY_W-1:0]                victim_all [SETS];
    logic [WAY_W-1:0]                wr_way;
    logic                            is_redundant;

    // Address split and request acceptance.
    always_comb begin
        accept        = req_valid && ready_q;
        sel_set       = req_addr[OFF_W +: SET_W];
        req_tag       = req_addr[ADDR_W-1 -: TAG_W];
        unused_offset = ^req_addr[OFF_W-1:0];
        req_ready     = ready_q;
    end

    rlf_txid_reg #(.TXID_W(TXID_W)) u_txid (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_begin (tx_begin),
        .eff_txid (eff_txid),
        .wrap_now (wrap_now)
    );

    // Read port of the selected set; a wrap in this cycle hides every entry.
    always_comb begin
        rd_valid = wrap_now ? '0 : valid_q[sel_set];
        for (int w = 0; w < WAYS; w++) begin
            rd_tag[w]  = tag_q[sel_set][w];
            rd_txid[w] = txid_q[sel_set][w];
        end
    end

    rlf_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .TXID_W(TXID_W)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (accept),
        .way_valid (rd_valid),
        .way_tag   (rd_tag),
        .way_txid  (rd_txid),
        .req_tag   (req_tag),
        .eff_txid  (eff_txid),
        .hit       (hit),
        .hit_way   (hit_way),
        .outcome   (outcome)
    );

    // One LRU tracker per set.
    genvar gs;
    generate
        for (gs = 0; gs < SETS; gs++) begin : g_lru
            logic            touch_s;
            logic [WAYS-1:0] valid_s;
            assign touch_s = accept && (sel_set == SET_W'(gs));
            assign valid_s = wrap_now ? '0 : valid_q[gs];
            rlf_lru_set #(.WAYS(WAYS)) u_lru (
                .clk       (clk),
                .rst_n     (rst_n),
                .touch     (touch_s),
                .touch_way (wr_way),
                .way_valid (valid_s),
                .victim    (victim_all[gs])
            );
        end
    endgenerate

    // Way to write: the hitting way, else the set's victim.
    always_comb begin
        wr_way       = hit ? hit_way : victim_all[sel_set];
        is_redundant = (outcome == LK_REDUNDANT);
    end

    // Valid bits: cleared on reset and on wrap, set by an accepted insert.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            if (wrap_now) valid_q <= '0;
            if (accept) valid_q[sel_set][wr_way] <= 1'b1;
        end
    end

    // Tag and transaction stamp of the written way.
    always_ff @(posedge clk) begin
        if (accept) begin
            tag_q[sel_set][wr_way]  <= req_tag;
            txid_q[sel_set][wr_way] <= eff_txid;
        end
    end

    // Handshake readiness: high from the cycle after reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) ready_q <= 1'b0;
        else        ready_q <= 1'b1;
    end

    // Registered response for the request accepted in this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid     <= 1'b0;
            resp_redundant <= 1'b0;
            resp_proceed   <= 1'b0;
        end else begin
            resp_valid     <= accept;
            resp_redundant <= accept && is_redundant;
            resp_proceed   <= accept && (outcome != LK_REDUNDANT);
        end
    end

    // R3
    resp_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> resp_valid);

    // R10
    no_resp_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> !resp_valid);

    // R3
    resp_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_redundant != resp_proceed));

    // R4
    stamp_refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && hit) |=> (txid_q[$past(sel_set)][$past(hit_way)] == $past(eff_txid)));

    // R8
    wrap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_now && !accept) |=> (valid_q == '0));

endmodule

// File: tb/redundant_log_filter_tb.sv
`timescale 1ns/1ps
module redundant_log_filter_tb;

    localparam int ADDR_W = 40;
    localparam int TXID_M = 256;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tx_begin = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_ready;
    logic              resp_valid;
    logic              resp_redundant;
    logic              resp_proceed;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    redundant_log_filter u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .tx_begin       (tx_begin),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_addr       (req_addr),
        .resp_valid     (resp_valid),
        .resp_redundant (resp_redundant),
        .resp_proceed   (resp_proceed)
    );

    // Behavioural model: 8 sets of up to 8 blocks with access timestamps.
    int unsigned m_tx;
    bit          m_val   [8][8];
    logic [30:0] m_tag   [8][8];
    int unsigned m_stamp_tx [8][8];
    longint      m_time  [8][8];
    longint      m_now;
    bit          exp_v;
    bit          exp_r;
    string       exp_tag;

    function automatic logic [ADDR_W-1:0] mk(input int unsigned tag, input int unsigned set,
                                             input int unsigned off);
        return {tag[30:0], set[2:0], off[5:0]};
    endfunction

    task automatic model_reset();
        m_tx = 0; m_now = 0;
        for (int s = 0; s < 8; s++)
            for (int w = 0; w < 8; w++) m_val[s][w] = 1'b0;
    endtask

    // Predict one cycle: returns the redundant flag for a request.
    task automatic model_step(input bit v, input logic [ADDR_W-1:0] a, input bit tb,
                              output bit red);
        int s;
        int hitw;
        int vic;
        logic [30:0] t;
        red = 1'b0;
        if (tb) begin
            m_tx = (m_tx + 1) % TXID_M;
            if (m_tx == 0)
                for (int s2 = 0; s2 < 8; s2++)
                    for (int w = 0; w < 8; w++) m_val[s2][w] = 1'b0;
        end
        if (!v) return;
        s = int'(a[8:6]);
        t = a[39:9];
        hitw = -1;
        for (int w = 0; w < 8; w++) if (m_val[s][w] && m_tag[s][w] == t) hitw = w;
        m_now++;
        if (hitw >= 0) begin
            red = (m_stamp_tx[s][hitw] == m_tx);
            m_stamp_tx[s][hitw] = m_tx;
            m_time[s][hitw] = m_now;
        end else begin
            vic = -1;
            for (int w = 0; w < 8; w++) if (!m_val[s][w] && vic < 0) vic = w;
            if (vic < 0) begin
                vic = 0;
                for (int w = 1; w < 8; w++) if (m_time[s][w] < m_time[s][vic]) vic = w;
            end
            m_val[s][vic] = 1'b1;
            m_tag[s][vic] = t;
            m_stamp_tx[s][vic] = m_tx;
            m_time[s][vic] = m_now;
        end
    endtask

    task automatic check_resp();
        tests++;
        if (req_ready !== 1'b1 || resp_valid !== exp_v ||
            (exp_v && (resp_redundant !== exp_r || resp_proceed !== !exp_r))) begin
            fails++;
            $display("FAIL %s: ready=%b valid=%b red=%b proc=%b expected ready=1 valid=%b red=%b proc=%b",
                     exp_tag, req_ready, resp_valid, resp_redundant, resp_proceed,
                     exp_v, exp_r, !exp_r);
        end
    endtask

    // Called at a negedge: check last cycle, apply new inputs, advance one cycle.
    task automatic step(input bit v, input logic [ADDR_W-1:0] a, input bit tb,
                        input string tag);
        bit red;
        check_resp();
        req_valid = v; req_addr = a; tx_begin = tb;
        model_step(v, a, tb, red);
        exp_v = v; exp_r = red; exp_tag = tag;
        @(negedge clk);
    endtask

    task automatic check_bit(input logic act, input logic expv, input string what);
        tests++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual=%b expected=%b", what, act, expv);
        end
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        model_reset();
        exp_v = 1'b0; exp_r = 1'b0; exp_tag = "R1";
        repeat (4) @(negedge clk);
        // R1: held in reset
        check_bit(req_ready, 1'b0, "R1 ready in reset");
        check_bit(resp_valid, 1'b0, "R1 resp_valid in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_bit(resp_valid, 1'b0, "R1 resp_valid after reset");
        @(negedge clk);
        check_bit(req_ready, 1'b1, "R1 ready after reset");

        // R1 / R3: first log proceeds, repeat is redundant
        step(1, mk(5, 1, 0), 0, "R1");
        step(1, mk(5, 1, 0), 0, "R3");
        // R2: offset bits ignored, set bits distinguish
        step(1, mk(5, 1, 63), 0, "R2");
        step(1, mk(5, 2, 0), 0, "R2");
        step(1, mk(5, 2, 17), 0, "R2");
        // R9: back-to-back same block
        step(1, mk(9, 4, 0), 0, "R9");
        step(1, mk(9, 4, 8), 0, "R9");
        step(1, mk(9, 4, 0), 0, "R9");
        // R10: idle cycles with garbage address, then table unchanged
        for (int i = 0; i < 5; i++) step(0, mk(5, 1, 0), 0, "R10");
        step(1, mk(5, 1, 0), 0, "R10");
        // R4: new transaction makes entries stale, refresh, then redundant
        step(0, '0, 1, "R4");
        step(1, mk(5, 1, 0), 0, "R4");
        step(1, mk(5, 1, 0), 0, "R4");
        // R5: repeat logged block in the same cycle as tx_begin
        step(1, mk(5, 1, 0), 0, "R5");
        step(1, mk(5, 1, 0), 1, "R5");
        step(1, mk(5, 1, 0), 0, "R5");
        // R6: fill set 5 with 8 blocks, all retained; other sets intact
        for (int i = 0; i < 8; i++) step(1, mk(100 + i, 5, 0), 0, "R6");
        for (int i = 0; i < 8; i++) step(1, mk(100 + i, 5, 4), 0, "R6");
        step(1, mk(5, 1, 0), 0, "R6");
        // R7: LRU replacement in set 3
        for (int i = 0; i < 8; i++) step(1, mk(200 + i, 3, 0), 0, "R7");
        step(1, mk(200, 3, 0), 0, "R7");
        step(1, mk(208, 3, 0), 0, "R7");
        step(1, mk(200, 3, 0), 0, "R7");
        step(1, mk(201, 3, 0), 0, "R7");
        step(1, mk(203, 3, 0), 0, "R7");
        step(1, mk(0, 3, 0), 0, "R7");
        step(1, mk(204, 3, 0), 0, "R7");
        // R8: wrap invalidates everything, request in wrap cycle recorded
        step(1, mk(77, 6, 0), 0, "R8");
        for (int i = 0; i < TXID_M; i++) begin
            if (m_tx == TXID_M - 1) step(1, mk(5, 1, 0), 1, "R8");
            else                    step(0, '0, 1, "R8");
        end
        step(1, mk(5, 1, 0), 0, "R8");
        step(1, mk(77, 6, 0), 0, "R8");
        step(1, mk(100, 5, 0), 0, "R8");
        // R3 / R7 / R5: random mix on a small address space
        seed = 32'h1234_5678;
        for (int i = 0; i < 3000; i++) begin
            bit v;
            bit tb;
            seed = seed * 1103515245 + 12345;
            v  = (seed[20:18] != 3'd0);
            tb = (seed[27:23] == 5'd0);
            step(v, mk(seed[13:10] % 12, seed[15:14], seed[5:0]), tb, "R3");
        end
        step(0, '0, 0, "R10");
        check_resp();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule